// File: doc/BRIEF.md
# Processor Local Bus Slave Interface

This block is a synchronous slave on a processor local bus whose data bits are numbered big-endian: bit 0 is the most significant bit. Byte address offset 0 maps to byte lane 0, which is data bits 0 to 7. Every input is sampled on the rising edge of the bus clock. Every response is registered and appears in the cycle after the request is sampled. An internal register file of `DEPTH` bus-wide words serves the accesses.

A master starts a transfer by pulling `start_n` low for one cycle. In that same cycle it presents the direction, the low 18 bits of its 32-bit address, a 2-bit size code, the burst marker and, for writes, the data and its lane parity. The slave answers with exactly one of three active-low responses: `ack_n` to accept, `err_n` for a bus error, or `retry_n` to ask the master to release the bus and repeat the cycle.

A burst is four word beats. The beat address steps by one word per beat and wraps inside the 16-byte aligned block that holds the start address. After the first beat, the master keeps `cont` high for each further beat. Dropping `cont` ends the burst early.

Top module: `plb_slave`

## Requirements
- R1: After reset, `ack_n`, `err_n` and `retry_n` are all high, and every register-file word reads as zero.
- R2: A single transfer sampled with `start_n` low gets its response in the next cycle only. A read with `ack_n` low returns the whole addressed word on `rdata`, with lane 0 (bits 0..7) holding byte offset 0.
- R3: Size code 2'b10 is a byte, 2'b01 a half-word and 2'b00 a word. Only the lanes the size and the offset select are written. Code 2'b11 is answered with `err_n`.
- R4: A transfer whose byte offset is not a multiple of its size, or whose size is wider than the data bus, is answered with `err_n` and changes no stored data.
- R5: Each `rpar[i]` gives odd parity over `rdata[8i..8i+7]`.
- R6: A write whose parity is even (wrong) in any selected lane is answered with `err_n`, and its data is discarded. Parity on lanes that are not selected is ignored.
- R7: A burst (`burst_n` low, word size) acknowledges four consecutive beats at byte offsets base, +4, +8, +12, taken modulo 16 inside the aligned 16-byte block. Each write beat takes the data presented in the cycle that beat is sampled.
- R8: A burst request with a size other than word gets a single `err_n` and no beats.
- R9: Low `cont` during a burst ends it with no response for that cycle, even when a parity error is present in the same cycle. No later beats are written.
- R10: Address bit 17 set selects a region that is not ready. Such a transfer gets one cycle of `retry_n` low and no write.
- R11: A word index at or above `DEPTH` is answered with `err_n`.
- R12: At most one of `ack_n`, `err_n` and `retry_n` is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_n | input | 1 | Active-low transfer start |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Low address bits of the master's address |
| tsize | input | 2 | Size code: 10 byte, 01 half-word, 00 word |
| burst_n | input | 1 | Low marks a burst request |
| cont | input | 1 | High requests the next burst beat |
| wdata | input | DW | Write data, bit 0 most significant |
| wpar | input | DW/8 | Odd parity per write lane |
| rdata | output | DW | Read data |
| rpar | output | DW/8 | Odd parity per read lane |
| ack_n | output | 1 | Active-low transfer acknowledge |
| err_n | output | 1 | Active-low transfer error acknowledge |
| retry_n | output | 1 | Active-low retry request |

## Verification
A parity fault and a burst abort can arrive in the same cycle. The bench provokes this by presenting a write beat with deliberately wrong parity on the very edge at which it drops `cont`. The judgment is that neither `ack_n` nor `err_n` falls in the next cycle, and a later read shows the aborted beat's word still at zero. A second coincidence is a parity error on an unselected lane together with a valid byte write: that write must be acknowledged and stored.

// File: rtl/plb_pkg.sv
package plb_pkg;
  typedef enum logic {ST_IDLE, ST_BURST} state_e;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'b10;

  // Odd parity bit for one byte lane
  function automatic logic odd_bit(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/plb_decode.sv
module plb_decode
  import plb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 18,
  localparam int NL   = DW / 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          burst,
  output logic [0:NL-1] lane_en,
  output logic [IW-1:0] idx,
  output logic          dec_err,
  output logic          dec_retry
);
  localparam int LB = $clog2(NL);
  localparam logic [2:0] NLB = 3'(NL);
  localparam logic [AW-2:0] DEPTHW = (AW-1)'(DEPTH);

  logic [2:0]    nb;
  logic [2:0]    offx;
  logic [AW-2:0] widx;

  always_comb begin
    unique case (size)
      SZ_BYTE: nb = 3'd1;
      SZ_HALF: nb = 3'd2;
      SZ_WORD: nb = 3'd4;
      default: nb = 3'd0;
    endcase
    offx      = {1'b0, addr[1:0] & 2'(NL - 1)};
    widx      = addr[AW-2:0] >> LB;
    idx       = widx[IW-1:0];
    dec_retry = addr[AW-1];
    dec_err   = !dec_retry &&
                ((nb == 3'd0) || (nb > NLB) ||
                 ((offx & (nb - 3'd1)) != 3'd0) ||
                 (burst && (size != SZ_WORD)) ||
                 (widx >= DEPTHW));
    for (int i = 0; i < NL; i++)
      lane_en[i] = (3'(i) >= offx) && (3'(i) < (offx + nb));
  end
endmodule

// File: rtl/plb_parity.sv
module plb_parity
  import plb_pkg::*;
#(
  parameter int DW  = 32,
  localparam int NL = DW / 8
) (
  input  logic [0:DW-1] wdata,
  input  logic [0:NL-1] wpar,
  input  logic [0:NL-1] lane_en,
  input  logic [0:DW-1] rdata,
  output logic          par_bad,
  output logic [0:NL-1] rpar
);
  logic [0:NL-1] bad_l;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign bad_l[g] = lane_en[g] && (odd_bit(wdata[8*g +: 8]) != wpar[g]);
    assign rpar[g]  = odd_bit(rdata[8*g +: 8]);
  end

  assign par_bad = |bad_l;
endmodule

// File: rtl/plb_regfile.sv
module plb_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int NL   = DW / 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [0:NL-1] lane_we,
  input  logic [IW-1:0] idx,
  input  logic [0:DW-1] wdata,
  output logic [0:DW-1] rdata
);
  logic [0:DW-1] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else if (we) begin
      for (int l = 0; l < NL; l++)
        if (lane_we[l]) mem_q[idx][8*l +: 8] <= wdata[8*l +: 8];
    end
  end

  assign rdata = mem_q[idx];

  // A write always touches at least one lane (R3)
  p_we_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (lane_we != '0));
endmodule

// File: rtl/plb_slave.sv
module plb_slave
  import plb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      tsize,
  input  logic            burst_n,
  input  logic            cont,
  input  logic [0:DW-1]   wdata,
  input  logic [0:DW/8-1] wpar,
  output logic [0:DW-1]   rdata,
  output logic [0:DW/8-1] rpar,
  output logic            ack_n,
  output logic            err_n,
  output logic            retry_n
);
  localparam int NL = DW / 8;
  localparam int IW = $clog2(DEPTH);

  // Reset: asserted asynchronously, released through two flops
  logic rs1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  state_e        state_q, state_d;
  logic [1:0]    beat_q, beat_d;
  logic [AW-1:0] base_q, base_d;
  logic          bwr_q, bwr_d;
  logic          ack_q, ack_d, err_q, err_d, rty_q, rty_d;
  logic [0:DW-1] rdata_q;

  logic          idle, valid, cur_wr, cur_burst, ok, we, rd_en;
  logic [1:0]    cur_size;
  logic [AW-1:0] cur_addr;
  logic [0:NL-1] lane_en;
  logic [IW-1:0] idx;
  logic          dec_err, dec_retry, par_bad;
  logic [0:DW-1] rf_rdata;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    valid     = idle ? !start_n : cont;
    cur_wr    = idle ? wr : bwr_q;
    cur_size  = idle ? tsize : SZ_WORD;
    cur_burst = idle ? !burst_n : 1'b1;
    cur_addr  = idle ? addr
                     : {base_q[AW-1:4], 2'(base_q[3:2] + beat_q), base_q[1:0]};
  end

  plb_decode #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_dec (
    .addr(cur_addr), .size(cur_size), .burst(cur_burst),
    .lane_en(lane_en), .idx(idx), .dec_err(dec_err), .dec_retry(dec_retry)
  );

  plb_parity #(.DW(DW)) u_par (
    .wdata(wdata), .wpar(wpar), .lane_en(lane_en), .rdata(rdata_q),
    .par_bad(par_bad), .rpar(rpar)
  );

  plb_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_s), .we(we), .lane_we(lane_en), .idx(idx),
    .wdata(wdata), .rdata(rf_rdata)
  );

  // Next-state logic
  always_comb begin
    ok      = valid && !dec_retry && !dec_err && !(cur_wr && par_bad);
    we      = ok && cur_wr;
    rd_en   = ok && !cur_wr;
    ack_d   = !ok;
    err_d   = !(valid && !dec_retry && !ok);
    rty_d   = !(valid && dec_retry);
    state_d = state_q;
    beat_d  = beat_q;
    base_d  = base_q;
    bwr_d   = bwr_q;
    if (idle) begin
      if (ok && cur_burst) begin
        state_d = ST_BURST;
        beat_d  = 2'd1;
        base_d  = addr;
        bwr_d   = wr;
      end
    end else if (!ok || beat_q == 2'd3) begin
      state_d = ST_IDLE;
      beat_d  = 2'd0;
    end else begin
      beat_d = beat_q + 2'd1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      beat_q  <= 2'd0;
      base_q  <= '0;
      bwr_q   <= 1'b0;
      ack_q   <= 1'b1;
      err_q   <= 1'b1;
      rty_q   <= 1'b1;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      base_q  <= base_d;
      bwr_q   <= bwr_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      rty_q   <= rty_d;
      if (rd_en) rdata_q <= rf_rdata;
    end
  end

  assign rdata   = rdata_q;
  assign ack_n   = ack_q;
  assign err_n   = err_q;
  assign retry_n = rty_q;

  p_one_resp_r12: assert property (@(posedge clk) disable iff (!rst_s)
    $countones({!ack_n, !err_n, !retry_n}) <= 1);

  p_retry_src_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !retry_n |-> $past(!start_n && state_q == ST_IDLE && addr[AW-1]));

  p_ack_has_req_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !ack_n |-> $past(!start_n || state_q == ST_BURST));

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_BURST && !cont) |=> (ack_n && err_n && state_q == ST_IDLE));

  p_write_acked_r6: assert property (@(posedge clk) disable iff (!rst_s)
    we |=> !ack_n);
endmodule

// File: tb/plb_slave_test.sv
`timescale 1ns/1ps
module plb_slave_test;
  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [3:0]  flip;
    logic [17:0] adr;
    logic [31:0] wd;
    logic [1:0]  rsp;   // 0 ack, 1 err, 2 retry
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    {1'b1, 2'b00, 4'h0, 18'h00000, 32'h11223344, 2'd0, 32'h0},        // R2 word write
    {1'b0, 2'b00, 4'h0, 18'h00000, 32'h0,        2'd0, 32'h11223344}, // R2 read back
    {1'b1, 2'b10, 4'h0, 18'h00001, 32'h00AA0000, 2'd0, 32'h0},        // R3 byte lane 1
    {1'b0, 2'b00, 4'h0, 18'h00000, 32'h0,        2'd0, 32'h11AA3344}, // R3
    {1'b1, 2'b01, 4'h0, 18'h00002, 32'h0000BEEF, 2'd0, 32'h0},        // R3 half lanes 2-3
    {1'b0, 2'b00, 4'h0, 18'h00000, 32'h0,        2'd0, 32'h11AABEEF}, // R3
    {1'b0, 2'b10, 4'h0, 18'h00003, 32'h0,        2'd0, 32'h11AABEEF}, // R2 byte read, full word
    {1'b1, 2'b01, 4'h0, 18'h00001, 32'hFFFFFFFF, 2'd1, 32'h0},        // R4 misaligned half
    {1'b1, 2'b00, 4'h0, 18'h00002, 32'hFFFFFFFF, 2'd1, 32'h0},        // R4 misaligned word
    {1'b0, 2'b11, 4'h0, 18'h00000, 32'h0,        2'd1, 32'h0},        // R3 reserved code
    {1'b1, 2'b00, 4'h1, 18'h00004, 32'hDEADBEEF, 2'd1, 32'h0},        // R6 bad lane 3
    {1'b0, 2'b00, 4'h0, 18'h00004, 32'h0,        2'd0, 32'h00000000}, // R6 discarded
    {1'b1, 2'b10, 4'h8, 18'h00005, 32'h00770000, 2'd0, 32'h0},        // R6 unselected lane bad
    {1'b0, 2'b00, 4'h0, 18'h00004, 32'h0,        2'd0, 32'h00770000}, // R6
    {1'b1, 2'b00, 4'h0, 18'h00040, 32'h12345678, 2'd1, 32'h0},        // R11 out of range
    {1'b0, 2'b00, 4'h0, 18'h20000, 32'h0,        2'd2, 32'h0},        // R10 read retry
    {1'b1, 2'b00, 4'h0, 18'h20000, 32'h55555555, 2'd2, 32'h0},        // R10 write retry
    {1'b1, 2'b10, 4'h4, 18'h00005, 32'h00550000, 2'd1, 32'h0},        // R6 selected lane bad
    {1'b0, 2'b00, 4'h0, 18'h00004, 32'h0,        2'd0, 32'h00770000}, // R6 kept
    {1'b0, 2'b01, 4'h0, 18'h00002, 32'h0,        2'd0, 32'h11AABEEF}  // R2 half read
  };

  logic        clk, rst_n, start_n, wr, burst_n, cont;
  logic [17:0] addr;
  logic [1:0]  tsize;
  logic [0:31] wdata, rdata;
  logic [0:3]  wpar, rpar;
  logic        ack_n, err_n, retry_n;
  int checks, errors;

  plb_slave uut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .wr(wr), .addr(addr),
    .tsize(tsize), .burst_n(burst_n), .cont(cont), .wdata(wdata), .wpar(wpar),
    .rdata(rdata), .rpar(rpar), .ack_n(ack_n), .err_n(err_n), .retry_n(retry_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [0:3] mkpar(input logic [0:31] d);
    logic [0:3] p;
    for (int i = 0; i < 4; i++) p[i] = ~^d[8*i +: 8];
    return p;
  endfunction

  function automatic logic [31:0] resp();
    if (!ack_n) return 0;
    if (!err_n) return 1;
    if (!retry_n) return 2;
    return 3;
  endfunction

  task automatic chk(input bit good, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rpar(input string req);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 4; i++) if (^{rdata[8*i +: 8], rpar[i]} != 1'b1) ok = 1'b0;
    chk(ok, req, {28'h0, rpar}, {28'h0, mkpar(rdata)});
  endtask

  task automatic single(input vec_t v, input int n);
    @(negedge clk);
    start_n = 1'b0; wr = v.wr; tsize = v.sz; addr = v.adr; burst_n = 1'b1;
    wdata = v.wd; wpar = mkpar(v.wd) ^ v.flip;
    @(negedge clk);
    start_n = 1'b1;
    chk(resp() == 32'(v.rsp), $sformatf("R2/vec%0d response", n), resp(), 32'(v.rsp));
    if (v.rsp == 2'd0 && !v.wr) begin
      chk(rdata == v.rd, $sformatf("R2/vec%0d rdata", n), rdata, v.rd);
      chk_rpar("R5 read parity");
    end
  endtask

  task automatic rd_word(input logic [17:0] a, input logic [31:0] exp, input string req);
    vec_t v;
    v = {1'b0, 2'b00, 4'h0, a, 32'h0, 2'd0, exp};
    single(v, 99);
    chk(rdata == exp, req, rdata, exp);
  endtask

  logic [31:0] bd [4];

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; start_n = 1'b1; wr = 1'b0; addr = '0; tsize = 2'b00;
    burst_n = 1'b1; cont = 1'b0; wdata = '0; wpar = '0;
    repeat (3) @(negedge clk);
    chk(ack_n && err_n && retry_n, "R1 outputs idle in reset",
        {29'h0, ack_n, err_n, retry_n}, 32'h7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ack_n && err_n && retry_n, "R1 outputs idle after reset",
        {29'h0, ack_n, err_n, retry_n}, 32'h7);
    rd_word(18'h0003C, 32'h0, "R1 memory cleared");

    for (int i = 0; i < NV; i++) single(VEC[i], i);

    // R7 burst write at 0x18: beats 0x18, 0x1C, 0x10, 0x14
    bd[0] = 32'hA0000001; bd[1] = 32'hA1000002; bd[2] = 32'hA2000003; bd[3] = 32'hA3000004;
    @(negedge clk);
    start_n = 1'b0; burst_n = 1'b0; wr = 1'b1; tsize = 2'b00; addr = 18'h00018;
    cont = 1'b1; wdata = bd[0]; wpar = mkpar(bd[0]);
    for (int b = 1; b <= 4; b++) begin
      @(negedge clk);
      start_n = 1'b1; burst_n = 1'b1;
      if (b < 4) begin wdata = bd[b]; wpar = mkpar(bd[b]); end
      else cont = 1'b0;
      chk(!ack_n && err_n, $sformatf("R7 write beat %0d ack", b - 1), resp(), 0);
    end
    @(negedge clk);
    chk(ack_n && err_n, "R7 no fifth beat", resp(), 3);
    rd_word(18'h00010, bd[2], "R7 wrap beat 2");
    rd_word(18'h00014, bd[3], "R7 wrap beat 3");
    rd_word(18'h0001C, bd[1], "R7 beat 1");

    // R7 burst read at 0x14: order 0x14, 0x18, 0x1C, 0x10
    @(negedge clk);
    start_n = 1'b0; burst_n = 1'b0; wr = 1'b0; tsize = 2'b00; addr = 18'h00014; cont = 1'b1;
    for (int b = 0; b < 4; b++) begin
      logic [31:0] e;
      e = bd[(b + 3) % 4];
      @(negedge clk);
      start_n = 1'b1; burst_n = 1'b1;
      if (b == 3) cont = 1'b0;
      chk(!ack_n && rdata == e, $sformatf("R7 read beat %0d", b), rdata, e);
      chk_rpar("R5 burst read parity");
    end

    // R8 burst with byte size
    @(negedge clk);
    start_n = 1'b0; burst_n = 1'b0; wr = 1'b1; tsize = 2'b10; addr = 18'h00018;
    cont = 1'b1; wdata = 32'hFFFFFFFF; wpar = mkpar(wdata);
    @(negedge clk);
    start_n = 1'b1; burst_n = 1'b1;
    chk(!err_n && ack_n, "R8 non-word burst error", resp(), 1);
    @(negedge clk);
    cont = 1'b0;
    chk(ack_n && err_n, "R8 no beats follow", resp(), 3);
    rd_word(18'h00018, bd[0], "R8 data unchanged");

    // R9 abort with a coincident parity fault
    @(negedge clk);
    start_n = 1'b0; burst_n = 1'b0; wr = 1'b1; tsize = 2'b00; addr = 18'h00020;
    cont = 1'b1; wdata = 32'hCAFE0001; wpar = mkpar(wdata);
    @(negedge clk);
    start_n = 1'b1; burst_n = 1'b1; cont = 1'b0;
    wdata = 32'hCAFE0002; wpar = ~mkpar(wdata);
    chk(!ack_n, "R9 beat 0 acked", resp(), 0);
    @(negedge clk);
    chk(ack_n && err_n, "R9 abort wins over parity error", resp(), 3);
    rd_word(18'h00020, 32'hCAFE0001, "R9 beat 0 stored");
    rd_word(18'h00024, 32'h0, "R9 later beat not written");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule